// File: doc/BRIEF.md
# SMBus Packet Error Code Checker

This block keeps a running CRC-8 packet error code over every byte that crosses the bus during an SMBus transfer, address bytes included. The byte framer upstream presents each completed byte on a one-cycle strobe and pulses a start input whenever a START condition begins a new transfer. It also marks the byte that carries the packet error code and tells the block whether the device is the master or the slave and whether it is receiving. The running code is always visible on `pec_tx`, so a transmitter can send it as its final byte.

When the marked byte arrives while the device is receiving, the block compares it with the code built from the bytes before it. It then issues a one-cycle acknowledge decision for that byte. A slave receiver acknowledges a matching code and refuses a wrong one. A master receiver always refuses the code byte, because it ends the read. A mismatch in either receive role sets a sticky error flag, which a write-one-to-clear strobe resets.

The controller has four states. `ST_IDLE` means the logic is off or no transfer has started. `ST_RUN` means bytes are being folded into the code. `ST_VERDICT` is the single cycle in which the acknowledge decision is driven. `ST_DONE` means the code byte has been seen and further bytes are ignored. The transitions are as follows:
- Disabling SMBus sends the controller to `ST_IDLE` from any state.
- A start, while enabled, sends it to `ST_RUN` from any state.
- In `ST_RUN`, a code byte goes to `ST_VERDICT` when receiving and to `ST_DONE` when transmitting.
- `ST_VERDICT` always goes to `ST_DONE`.
- `ST_IDLE` and `ST_DONE` otherwise stay where they are.

Top module: `smbus_pec_checker`

## Requirements
- R1: After reset, `pec_err` is 0, `ack_ovr_vld` is 0 and `pec_tx` is 0x00.
- R2: Each strobed byte that is not marked as the code byte is folded into a CRC-8 with polynomial 0x07 (x^8+x^2+x+1), initial value 0x00, most significant bit first, no final inversion. The new value appears on `pec_tx` one cycle after the strobe.
- R3: A start while SMBus is enabled resets the code to 0x00 one cycle later. A byte strobed in the same cycle as the start is discarded.
- R4: When a slave receiver gets a code byte equal to the running code, `ack_ovr_vld` is high for exactly the following cycle with `ack_ovr_nack` = 0, and `pec_err` stays 0.
- R5: When a slave receiver gets a code byte that differs from the running code, `ack_ovr_nack` = 1 in that decision cycle, and `pec_err` is 1 from the cycle after it.
- R6: A master receiver always gets `ack_ovr_nack` = 1 for the code byte. `pec_err` is set only when the code differs.
- R7: `pec_err` stays set until `err_clr` is pulsed, and clears one cycle after the pulse. If a new error arrives in the same cycle as the clear, the error wins.
- R8: While `smbus_en` is 0, strobed bytes do not change `pec_tx`, and no acknowledge decision or error is produced.
- R9: A code byte seen while transmitting (`rx_dir` = 0) produces no acknowledge decision and no error, and leaves `pec_tx` unchanged.
- R10: After the code byte, further bytes leave `pec_tx` unchanged until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smbus_en | input | 1 | SMBus mode enable; code logic is idle when 0 |
| xfer_start | input | 1 | One-cycle pulse at a START condition |
| byte_vld | input | 1 | One-cycle strobe: `byte_data` holds a completed bus byte |
| byte_data | input | 8 | Byte seen on the bus |
| byte_is_pec | input | 1 | Qualifies the strobed byte as the packet error code |
| role_master | input | 1 | 1 = master, 0 = slave |
| rx_dir | input | 1 | 1 = this device receives the data bytes |
| err_clr | input | 1 | Write-one-to-clear strobe for `pec_err` |
| pec_err | output | 1 | Sticky code mismatch flag |
| ack_ovr_vld | output | 1 | Acknowledge decision valid for the code byte |
| ack_ovr_nack | output | 1 | 1 = refuse (NACK) the code byte, 0 = acknowledge it |
| pec_tx | output | 8 | Running code value, ready to be transmitted |

## Verification
Every byte value from 0x00 to 0xFF is sent as the first byte after a start, and the running code is compared with an arithmetic CRC model. This separates polynomial, bit-order and initial-value faults. The same sweep follows each byte with a code byte that is right or deliberately wrong and alternates between master and slave, so each acknowledge outcome is seen under both roles and can be told apart from a role-blind policy. Multi-byte transfers with an address byte show that the code chains across bytes and is restarted by a start. Directed cases cover the disabled state, transmit direction, bytes after the code byte, a start colliding with a strobe, and a clear colliding with a new error.

// File: rtl/pec_pkg.sv
package pec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUN     = 2'd1,
        ST_VERDICT = 2'd2,
        ST_DONE    = 2'd3
    } pec_state_t;

endpackage

// File: rtl/pec_crc_engine.sv
module pec_crc_engine #(
    parameter int              WIDTH = 8,
    parameter logic [WIDTH-1:0] POLY = 8'h07,
    parameter logic [WIDTH-1:0] INIT = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             upd,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] crc
);

    localparam int STAGES = WIDTH;

    logic [WIDTH-1:0] stage [STAGES+1];

    assign stage[0] = crc ^ din;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_bit
            assign stage[i+1] = stage[i][WIDTH-1]
                              ? ({stage[i][WIDTH-2:0], 1'b0} ^ POLY)
                              :  {stage[i][WIDTH-2:0], 1'b0};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc <= INIT;
        else if (clr)
            crc <= INIT;
        else if (upd)
            crc <= stage[STAGES];
    end

    a_r3_clear_restores_init: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc == INIT));

    a_r2_hold_without_update: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !upd) |=> $stable(crc));

endmodule

// File: rtl/pec_ack_policy.sv
module pec_ack_policy (
    input  logic clk,
    input  logic rst_n,
    input  logic verdict,
    input  logic is_master,
    input  logic mismatch,
    input  logic err_clr,
    output logic ovr_vld,
    output logic ovr_nack,
    output logic err
);

    logic err_set;

    assign err_set  = verdict && mismatch;
    assign ovr_vld  = verdict;
    assign ovr_nack = verdict && (is_master || mismatch);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            err <= 1'b0;
        else if (err_set)
            err <= 1'b1;
        else if (err_clr)
            err <= 1'b0;
    end

    a_r7_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !err_clr) |=> err);

    a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_vld && mismatch) |=> err);

    a_r4_match_slave_acks: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_vld && !is_master && !mismatch) |-> !ovr_nack);

endmodule

// File: rtl/smbus_pec_checker.sv
module smbus_pec_checker
    import pec_pkg::*;
#(
    parameter int               DW   = 8,
    parameter logic [DW-1:0]    POLY = 8'h07,
    parameter logic [DW-1:0]    INIT = 8'h00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smbus_en,
    input  logic          xfer_start,
    input  logic          byte_vld,
    input  logic [DW-1:0] byte_data,
    input  logic          byte_is_pec,
    input  logic          role_master,
    input  logic          rx_dir,
    input  logic          err_clr,
    output logic          pec_err,
    output logic          ack_ovr_vld,
    output logic          ack_ovr_nack,
    output logic [DW-1:0] pec_tx
);

    pec_state_t state, state_nxt;

    logic          live_byte;
    logic          crc_clr;
    logic          crc_upd;
    logic          pec_capture;
    logic          mism_q;
    logic          master_q;
    logic          in_verdict;
    logic [DW-1:0] crc_val;

    // A strobe counts only when enabled, running and not cancelled by a start
    assign live_byte   = smbus_en && !xfer_start && (state == ST_RUN) && byte_vld;
    assign crc_clr     = smbus_en && xfer_start;
    assign crc_upd     = live_byte && !byte_is_pec;
    assign pec_capture = live_byte && byte_is_pec && rx_dir;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        if (!smbus_en) begin
            state_nxt = ST_IDLE;
        end else if (xfer_start) begin
            state_nxt = ST_RUN;
        end else begin
            unique case (state)
                ST_IDLE:    state_nxt = ST_IDLE;
                ST_RUN:     if (byte_vld && byte_is_pec)
                                state_nxt = rx_dir ? ST_VERDICT : ST_DONE;
                ST_VERDICT: state_nxt = ST_DONE;
                ST_DONE:    state_nxt = ST_DONE;
                default:    state_nxt = ST_IDLE;
            endcase
        end
    end

    // Outputs derived from state
    always_comb begin
        in_verdict = 1'b0;
        unique case (state)
            ST_VERDICT: in_verdict = 1'b1;
            default:    in_verdict = 1'b0;
        endcase
    end

    // Comparison result and role captured with the code byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mism_q   <= 1'b0;
            master_q <= 1'b0;
        end else if (pec_capture) begin
            mism_q   <= (byte_data != crc_val);
            master_q <= role_master;
        end
    end

    pec_crc_engine #(
        .WIDTH (DW),
        .POLY  (POLY),
        .INIT  (INIT)
    ) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .upd   (crc_upd),
        .din   (byte_data),
        .crc   (crc_val)
    );

    pec_ack_policy u_policy (
        .clk       (clk),
        .rst_n     (rst_n),
        .verdict   (in_verdict),
        .is_master (master_q),
        .mismatch  (mism_q),
        .err_clr   (err_clr),
        .ovr_vld   (ack_ovr_vld),
        .ovr_nack  (ack_ovr_nack),
        .err       (pec_err)
    );

    assign pec_tx = crc_val;

    a_r4_one_cycle_decision: assert property (@(posedge clk) disable iff (!rst_n)
        ack_ovr_vld |=> !ack_ovr_vld);

    a_r6_master_always_nacks: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_is_pec && role_master && rx_dir && smbus_en && !xfer_start
         && state == ST_RUN) |=> (ack_ovr_vld && ack_ovr_nack));

    a_r5_nack_slave_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_ovr_vld && ack_ovr_nack && !master_q) |=> pec_err);

    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !smbus_en |=> ($stable(pec_tx) && !ack_ovr_vld));

    a_r9_tx_no_decision: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_is_pec && !rx_dir && !xfer_start) |=> !ack_ovr_vld);

    a_r10_done_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !xfer_start) |=> $stable(pec_tx));

endmodule

// File: tb/smbus_pec_checker_test.sv
module smbus_pec_checker_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smbus_en = 1'b0;
    logic       xfer_start = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       byte_is_pec = 1'b0;
    logic       role_master = 1'b0;
    logic       rx_dir = 1'b0;
    logic       err_clr = 1'b0;
    logic       pec_err;
    logic       ack_ovr_vld;
    logic       ack_ovr_nack;
    logic [7:0] pec_tx;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    smbus_pec_checker uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .smbus_en     (smbus_en),
        .xfer_start   (xfer_start),
        .byte_vld     (byte_vld),
        .byte_data    (byte_data),
        .byte_is_pec  (byte_is_pec),
        .role_master  (role_master),
        .rx_dir       (rx_dir),
        .err_clr      (err_clr),
        .pec_err      (pec_err),
        .ack_ovr_vld  (ack_ovr_vld),
        .ack_ovr_nack (ack_ovr_nack),
        .pec_tx       (pec_tx)
    );

    // Arithmetic model: polynomial division of (crc ^ byte) * x^8 by x^8+x^2+x+1
    function automatic logic [7:0] model(input logic [7:0] c, input logic [7:0] b);
        logic [15:0] r = {c ^ b, 8'h00};
        for (int k = 15; k >= 8; k--)
            if (r[k]) r = r ^ (16'h0107 << (k - 8));
        return r[7:0];
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic start();
        xfer_start = 1'b1;
        tick();
        xfer_start = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input logic pec);
        byte_data = b; byte_is_pec = pec; byte_vld = 1'b1;
        tick();
        byte_vld = 1'b0; byte_is_pec = 1'b0;
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] exp;
        tick(); tick();
        // R1 reset state
        chk("R1 pec_err", {7'd0, pec_err}, 8'h00);
        chk("R1 ack_ovr_vld", {7'd0, ack_ovr_vld}, 8'h00);
        chk("R1 pec_tx", pec_tx, 8'h00);
        rst_n = 1'b1;
        smbus_en = 1'b1;
        rx_dir = 1'b1;
        tick();

        // Sweep all first bytes; alternate role and PEC correctness
        for (int b = 0; b < 256; b++) begin
            logic role, bad;
            logic [7:0] sent;
            role = b[0];
            bad  = b[1];
            start();
            chk("R3 cleared", pec_tx, 8'h00);
            send(b[7:0], 1'b0);
            exp = model(8'h00, b[7:0]);
            chk("R2 one byte", pec_tx, exp);
            role_master = role;
            sent = bad ? (exp ^ 8'h5A) : exp;
            send(sent, 1'b1);
            chk("R4 decision valid", {7'd0, ack_ovr_vld}, 8'h01);
            chk(role ? "R6 master nack" : (bad ? "R5 slave nack" : "R4 slave ack"),
                {7'd0, ack_ovr_nack}, {7'd0, (role | bad)});
            tick();
            chk("R4 decision one cycle", {7'd0, ack_ovr_vld}, 8'h00);
            chk(role ? "R6 master error" : "R5 slave error", {7'd0, pec_err}, {7'd0, bad});
            tick();
            chk("R7 sticky", {7'd0, pec_err}, {7'd0, bad});
            err_clr = 1'b1; tick(); err_clr = 1'b0;
            chk("R7 cleared", {7'd0, pec_err}, 8'h00);
        end

        // Multi-byte transfer with address byte
        role_master = 1'b0;
        start();
        exp = 8'h00;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] d;
            d = 8'hA6 + 8'(i * 37);
            send(d, 1'b0);
            exp = model(exp, d);
            chk("R2 chained", pec_tx, exp);
        end
        send(exp, 1'b1);
        chk("R4 multi ack", {6'd0, ack_ovr_vld, ack_ovr_nack}, 8'h02);
        tick();
        chk("R4 multi no error", {7'd0, pec_err}, 8'h00);
        // R10 bytes after the code byte are ignored
        send(8'h33, 1'b0);
        chk("R10 frozen", pec_tx, exp);

        // R3 start colliding with a byte strobe
        byte_data = 8'hC3; byte_vld = 1'b1; xfer_start = 1'b1;
        tick();
        byte_vld = 1'b0; xfer_start = 1'b0;
        chk("R3 start wins", pec_tx, 8'h00);

        // R7 error set in the same cycle as a clear
        send(8'h11, 1'b0);
        exp = model(8'h00, 8'h11);
        send(~exp, 1'b1);
        err_clr = 1'b1; tick(); err_clr = 1'b0;
        chk("R7 set beats clear", {7'd0, pec_err}, 8'h01);
        err_clr = 1'b1; tick(); err_clr = 1'b0;
        chk("R7 clear after", {7'd0, pec_err}, 8'h00);

        // R9 transmitter code byte
        rx_dir = 1'b0;
        start();
        send(8'h42, 1'b0);
        exp = model(8'h00, 8'h42);
        send(8'h99, 1'b1);
        chk("R9 no decision", {7'd0, ack_ovr_vld}, 8'h00);
        tick();
        chk("R9 no error", {7'd0, pec_err}, 8'h00);
        chk("R9 pec_tx held", pec_tx, exp);
        rx_dir = 1'b1;

        // R8 disabled
        start();
        send(8'h5C, 1'b0);
        exp = model(8'h00, 8'h5C);
        smbus_en = 1'b0;
        tick();
        send(8'h77, 1'b0);
        chk("R8 pec_tx unchanged", pec_tx, exp);
        send(8'h00, 1'b1);
        chk("R8 no decision", {7'd0, ack_ovr_vld}, 8'h00);
        tick();
        chk("R8 no error", {7'd0, pec_err}, 8'h00);
        xfer_start = 1'b1; tick(); xfer_start = 1'b0;
        chk("R8 start ignored", pec_tx, exp);
        smbus_en = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule